// File: doc/BRIEF.md
# Prescaled Countdown Timer

This block is a 32-bit down-counter for a per-core interrupt unit. A power-of-two prescaler divides the bus clock. Software programs it through an indexed register port. Four registers are visible: a timer control entry, a start value, a read-only live count and a divide selector.

When software writes the start value, the count is loaded and the prescaler phase is cleared. The count then falls by one on each prescaled tick. A mode bit in the control entry selects one of two behaviours. In single-shot mode the count stops at zero and the block requests one interrupt. In repeating mode the count reloads and requests an interrupt on every period.

Each request is a one-cycle pulse. It carries the 8-bit vector held in the low byte of the control entry and is marked edge-triggered. A mask bit in the control entry blocks every request without stopping the count.

Top module: `cdt_top`

## Requirements
- R1: A write to the divide selector (index 0x3E) keeps only bits 0, 1 and 3 of the data. A read returns that masked value.
- R2: The prescale shift is ({bit3, bit1, bit0} + 1) mod 8, and one tick occurs every 2^shift clocks. Selector 0xB (code 7) gives one tick per clock, 0x0 gives one tick per 2 clocks, and 0x8 gives one tick per 32 clocks.
- R3: A write to the start value (index 0x38) loads the live count with the written data and clears the prescaler phase. After that write, tick j falls j*2^shift clocks later.
- R4: In single-shot mode (control bit 17 = 0), the live count after j ticks is start − j, held at 0. Exactly one request is made, on tick start+1.
- R5: In repeating mode (control bit 17 = 1), a request is made every start+1 ticks. The live count reloads to the start value after it reaches 0.
- R6: In repeating mode, a start value of zero produces no requests.
- R7: While control bit 16 (mask) is 1, no request is made.
- R8: The live count (index 0x39) is read-only, and writes to it change nothing.
- R9: After reset, the control entry reads 0x00010000, and the start value, live count and divide selector read 0. No request is made.
- R10: A request is a single-cycle `exp_valid` pulse. `exp_vector` equals control bits 7:0 and `exp_edge` is 1.
- R11: A read returns data one clock after `rd_en`, with `rd_valid` high. An unmapped index reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | 8 | Register index for writes |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_idx | input | 8 | Register index for reads |
| rd_data | output | 32 | Registered read data |
| rd_valid | output | 1 | Read data valid |
| exp_valid | output | 1 | One-cycle expiry request |
| exp_vector | output | 8 | Vector carried by the request |
| exp_edge | output | 1 | Edge-triggered flag for the request |

## Verification
Some properties are checked by assertions on every cycle:
- a request never lasts two cycles;
- the live count never exceeds the start value;
- a start write loads the count exactly;
- a request never follows a masked cycle;
- a request never comes from a zero-period repeating timer;
- a single-shot count resting at zero stays there.

Other behaviour can only be shown by the directed scenarios in the bench:
- the exact clock of each expiry for several divide selectors;
- the live-count values read mid-run;
- the masking of the divide selector;
- writes to the read-only index being ignored.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
  localparam int IDX_W = 8;
  localparam int DATA_W = 32;
  localparam int SHIFT_W = 3;

  localparam logic [IDX_W-1:0] IDX_CTRL  = 8'h32;
  localparam logic [IDX_W-1:0] IDX_START = 8'h38;
  localparam logic [IDX_W-1:0] IDX_LIVE  = 8'h39;
  localparam logic [IDX_W-1:0] IDX_DIV   = 8'h3E;

  localparam logic [DATA_W-1:0] DIV_KEEP   = 32'h0000_000B;
  localparam logic [DATA_W-1:0] CTRL_RESET = 32'h0001_0000;
  localparam int BIT_MASK   = 16;
  localparam int BIT_REPEAT = 17;

  // Pack {b3,b1,b0}, add one, wrap to 3 bits.
  function automatic logic [SHIFT_W-1:0] shift_of(input logic [DATA_W-1:0] div);
    logic [SHIFT_W-1:0] code;
    code = {div[3], div[1:0]};
    return code + 3'd1;
  endfunction
endpackage

// File: rtl/cdt_regs.sv
module cdt_regs
  import cdt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [CNT_W-1:0]  live_cnt,
  output logic [DATA_W-1:0] ctrl_q,
  output logic [CNT_W-1:0]  start_q,
  output logic [DATA_W-1:0] div_q,
  output logic              load,
  output logic [CNT_W-1:0]  load_val,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);
  logic [DATA_W-1:0] rd_mux;

  assign load     = wr_en && (wr_idx == IDX_START);
  assign load_val = wr_data[CNT_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= CTRL_RESET;
      start_q <= '0;
      div_q   <= '0;
    end else if (wr_en) begin
      case (wr_idx)
        IDX_CTRL:  ctrl_q  <= wr_data;
        IDX_START: start_q <= wr_data[CNT_W-1:0];
        IDX_DIV:   div_q   <= wr_data & DIV_KEEP;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (rd_idx)
      IDX_CTRL:  rd_mux = ctrl_q;
      IDX_START: rd_mux = DATA_W'(start_q);
      IDX_LIVE:  rd_mux = DATA_W'(live_cnt);
      IDX_DIV:   rd_mux = div_q;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      rd_data  <= rd_en ? rd_mux : '0;
    end
  end

  AST_DIV_KEPT: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_idx == IDX_DIV) |=> (div_q == ($past(wr_data) & DIV_KEEP))); // R1
endmodule

// File: rtl/cdt_prescaler.sv
module cdt_prescaler
  import cdt_pkg::*;
#(
  parameter int SHW = SHIFT_W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic [SHW-1:0] shift,
  output logic           tick
);
  localparam int PRE_W = (1 << SHW) - 1;

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] phase_mask;

  assign phase_mask = PRE_W'((1 << shift) - 1);
  assign tick = !load && ((pre_q & phase_mask) == phase_mask);

  always_ff @(posedge clk) begin
    if (rst || load) pre_q <= '0;
    else             pre_q <= pre_q + 1'b1;
  end

  AST_PHASE_CLEAR: assert property (@(posedge clk) disable iff (rst)
    load |=> (pre_q == '0)); // R3
endmodule

// File: rtl/cdt_counter.sv
module cdt_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] start_q,
  input  logic             tick,
  input  logic             repeat_mode,
  output logic [CNT_W-1:0] cnt_q,
  output logic             fire
);
  logic armed_q;
  logic fire_d;
  logic [CNT_W-1:0] cnt_d;
  logic armed_d;

  always_comb begin
    cnt_d   = cnt_q;
    armed_d = armed_q;
    fire_d  = 1'b0;
    if (load) begin
      cnt_d   = load_val;
      armed_d = 1'b1;
    end else if (tick) begin
      if (cnt_q != '0) begin
        cnt_d = cnt_q - 1'b1;
      end else if (repeat_mode) begin
        if (start_q != '0) begin
          cnt_d  = start_q;
          fire_d = 1'b1;
        end
      end else if (armed_q) begin
        armed_d = 1'b0;
        fire_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
      fire    <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      armed_q <= armed_d;
      fire    <= fire_d;
    end
  end

  AST_LOAD_EXACT: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt_q == $past(load_val))); // R3
  AST_CNT_BOUNDED: assert property (@(posedge clk) disable iff (rst)
    !load |=> (cnt_q <= start_q)); // R5
  AST_ONESHOT_REST: assert property (@(posedge clk) disable iff (rst)
    (!repeat_mode && !load && cnt_q == '0) |=> (cnt_q == '0)); // R4
endmodule

// File: rtl/cdt_top.sv
module cdt_top
  import cdt_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int VEC_W = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [7:0]  wr_idx,
  input  logic [31:0] wr_data,
  input  logic        rd_en,
  input  logic [7:0]  rd_idx,
  output logic [31:0] rd_data,
  output logic        rd_valid,
  output logic        exp_valid,
  output logic [7:0]  exp_vector,
  output logic        exp_edge
);
  logic [DATA_W-1:0]  ctrl_q;
  logic [CNT_W-1:0]   start_q;
  logic [DATA_W-1:0]  div_q;
  logic               load;
  logic [CNT_W-1:0]   load_val;
  logic               tick;
  logic [CNT_W-1:0]   cnt_q;
  logic               fire;
  logic               mask_q;
  logic [VEC_W-1:0]   vec_q;

  cdt_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_en(rd_en), .rd_idx(rd_idx), .live_cnt(cnt_q),
    .ctrl_q(ctrl_q), .start_q(start_q), .div_q(div_q),
    .load(load), .load_val(load_val),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  cdt_prescaler #(.SHW(SHIFT_W)) u_pre (
    .clk(clk), .rst(rst), .load(load),
    .shift(shift_of(div_q)), .tick(tick)
  );

  cdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .load(load), .load_val(load_val),
    .start_q(start_q), .tick(tick),
    .repeat_mode(ctrl_q[BIT_REPEAT]),
    .cnt_q(cnt_q), .fire(fire)
  );

  // The counter's fire is registered, so mask and vector are sampled in the
  // same cycle to align with it.
  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= 1'b1;
      vec_q  <= '0;
    end else begin
      mask_q <= ctrl_q[BIT_MASK];
      vec_q  <= ctrl_q[VEC_W-1:0];
    end
  end

  assign exp_valid  = fire && !mask_q;
  assign exp_vector = exp_valid ? vec_q : '0;
  assign exp_edge   = exp_valid;

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    exp_valid |=> !exp_valid); // R10
  AST_MASK_QUIET: assert property (@(posedge clk) disable iff (rst)
    exp_valid |-> !$past(ctrl_q[BIT_MASK])); // R7
  AST_ZERO_PERIOD: assert property (@(posedge clk) disable iff (rst)
    (exp_valid && $past(ctrl_q[BIT_REPEAT])) |-> ($past(start_q) != '0)); // R6
endmodule

// File: tb/sim_cdt_top.sv
module sim_cdt_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en;
  logic [7:0]  wr_idx;
  logic [31:0] wr_data;
  logic        rd_en;
  logic [7:0]  rd_idx;
  logic [31:0] rd_data;
  logic        rd_valid;
  logic        exp_valid;
  logic [7:0]  exp_vector;
  logic        exp_edge;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  cdt_top u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_en(rd_en), .rd_idx(rd_idx), .rd_data(rd_data), .rd_valid(rd_valid),
    .exp_valid(exp_valid), .exp_vector(exp_vector), .exp_edge(exp_edge)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; wr_en = 0; rd_en = 0; wr_idx = 0; wr_data = 0; rd_idx = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 0;
  endtask

  // Returns at the negedge after the write's edge (E0).
  task automatic wr(input logic [7:0] idx, input logic [31:0] d);
    wr_en = 1; wr_idx = idx; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [7:0] idx, output logic [31:0] d, output bit v);
    rd_en = 1; rd_idx = idx;
    @(posedge clk);
    @(negedge clk);
    rd_en = 0;
    d = rd_data; v = rd_valid;
  endtask

  // Counts edges after E0 until the first pulse, limit lim.
  task automatic wait_exp(input int lim, output int k, output logic [7:0] vec, output bit edg);
    k = -1; vec = 0; edg = 0;
    for (int i = 1; i <= lim; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (exp_valid) begin
        k = i; vec = exp_vector; edg = exp_edge;
        break;
      end
    end
  endtask

  task automatic count_exp(input int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (exp_valid) c++;
    end
  endtask

  task automatic t_reset();
    logic [31:0] d; bit v;
    do_reset();
    chk(exp_valid == 0, "R9 no request", exp_valid, 0);
    rd(8'h32, d, v); chk(d == 32'h0001_0000, "R9 ctrl", d, 32'h0001_0000);
    chk(v == 1, "R11 rd_valid", v, 1);
    rd(8'h38, d, v); chk(d == 0, "R9 start", d, 0);
    rd(8'h39, d, v); chk(d == 0, "R9 live", d, 0);
    rd(8'h3E, d, v); chk(d == 0, "R9 div", d, 0);
    rd(8'h07, d, v); chk(d == 0, "R11 unmapped", d, 0);
  endtask

  task automatic t_divmask();
    logic [31:0] d; bit v;
    do_reset();
    wr(8'h3E, 32'hFFFF_FFFF);
    rd(8'h3E, d, v); chk(d == 32'hB, "R1 div keep", d, 32'hB);
  endtask

  task automatic t_oneshot();
    logic [31:0] d; bit v; int k; logic [7:0] vec; bit edg; int c;
    do_reset();
    wr(8'h3E, 32'h0);
    wr(8'h32, 32'h0000_0041);
    wr(8'h38, 32'd5);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rd(8'h39, d, v); chk(d == 4, "R4 live midway", d, 4);
    // The read consumed E4, so the pulse is expected at E12, i.e. 8 edges later.
    wait_exp(40, k, vec, edg);
    chk(k == 8, "R2 R4 expiry at tick start+1 (div2)", k, 8);
    chk(vec == 8'h41, "R10 vector", vec, 8'h41);
    chk(edg == 1, "R10 edge flag", edg, 1);
    @(posedge clk); @(negedge clk);
    chk(exp_valid == 0, "R10 single cycle", exp_valid, 0);
    count_exp(40, c); chk(c == 0, "R4 fires once", c, 0);
    rd(8'h39, d, v); chk(d == 0, "R4 held at 0", d, 0);
    wr(8'h39, 32'h1234);
    rd(8'h39, d, v); chk(d == 0, "R8 live read-only", d, 0);
    rd(8'h38, d, v); chk(d == 5, "R8 start unchanged", d, 5);
  endtask

  task automatic t_div32();
    int k; logic [7:0] vec; bit edg;
    do_reset();
    wr(8'h3E, 32'h8);
    wr(8'h32, 32'h0000_0022);
    wr(8'h38, 32'd0);
    wait_exp(100, k, vec, edg);
    chk(k == 32, "R2 R3 div32 first tick", k, 32);
  endtask

  task automatic t_periodic();
    logic [31:0] d; bit v; int k1, k2, k3; logic [7:0] vec; bit edg;
    do_reset();
    wr(8'h3E, 32'hB);
    wr(8'h32, 32'h0002_0077);
    wr(8'h38, 32'd3);
    wait_exp(50, k1, vec, edg); chk(k1 == 4, "R5 first period", k1, 4);
    chk(vec == 8'h77, "R10 periodic vector", vec, 8'h77);
    wait_exp(50, k2, vec, edg); chk(k2 == 4, "R5 second period", k2, 4);
    wait_exp(50, k3, vec, edg); chk(k3 == 4, "R5 third period", k3, 4);
    rd(8'h39, d, v); chk(d == 3, "R5 reload", d, 3);
  endtask

  task automatic t_zero_period();
    int c;
    do_reset();
    wr(8'h3E, 32'hB);
    wr(8'h32, 32'h0002_0010);
    wr(8'h38, 32'd0);
    count_exp(50, c); chk(c == 0, "R6 zero period quiet", c, 0);
  endtask

  task automatic t_mask();
    int c, k; logic [7:0] vec; bit edg;
    do_reset();
    wr(8'h3E, 32'hB);
    wr(8'h32, 32'h0003_0020);
    wr(8'h38, 32'd2);
    count_exp(20, c); chk(c == 0, "R7 masked", c, 0);
    wr(8'h32, 32'h0002_0020);
    wait_exp(10, k, vec, edg);
    chk(k > 0, "R7 unmask resumes", k, 1);
  endtask

  task automatic t_restart();
    int k; logic [7:0] vec; bit edg;
    do_reset();
    wr(8'h3E, 32'h1);
    wr(8'h32, 32'h0000_0055);
    wr(8'h38, 32'd9);
    repeat (5) @(posedge clk);
    @(negedge clk);
    wr(8'h38, 32'd1);
    wait_exp(60, k, vec, edg);
    chk(k == 8, "R3 restart (div4, start 1)", k, 8);
  endtask

  initial begin
    rst = 1; wr_en = 0; rd_en = 0; wr_idx = 0; wr_data = 0; rd_idx = 0;
    t_reset();
    t_divmask();
    t_oneshot();
    t_div32();
    t_periodic();
    t_zero_period();
    t_mask();
    t_restart();
    done = 1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule